// File: doc/BRIEF.md
# Scanline Sprite Evaluator

This block picks the sprites that appear on the next display line. It is started once per line during horizontal blanking. It then walks a 32-entry attribute table in video memory, four bytes per entry: vertical position, horizontal position, pattern number, and a colour byte that holds an early-shift flag in bit 7. Every entry that covers the requested line is accepted, up to four of them, in table order. For each accepted sprite it loads the horizontal position, the pattern number and the colour into one of four slot records. A later pixel stage reads those records.

A vertical position of 208 marks the end of the table for that line. A fifth sprite that covers the line stops the walk and raises a sticky overflow flag with the index of that sprite. The flag is released by a status-read pulse. The block reads memory through a simple port: it raises a read strobe with an address, and the data arrives on the following cycle.

Top module: `spr_line_eval`

## Requirements
- R1: After reset, busy, done, mem_rd, slot_cnt, ovf_flag and ovf_idx are all zero.
- R2: Byte k (0 to 3) of table entry i is read at address sat_base*128 + 4*i + k. The read data is taken on the cycle after mem_rd is high.
- R3: An entry with vertical byte Y covers line L when (L - Y - 1) mod 256 is less than the sprite height. The height is 8, or 16 when big_spr is set, and mag_spr doubles it. Y = 255 therefore covers line 0 first.
- R4: Covering entries are accepted in ascending table order, at most four of them. The first accepted entry goes to slot 0 and the next to slot 1, and so on. slot_cnt gives the number accepted.
- R5: A vertical byte of 208 ends the walk. Neither that entry nor any later entry is read or accepted. With no such byte, all 32 entries are examined.
- R6: A covering entry found when four slots are full sets ovf_flag, records its index in ovf_idx and ends the walk.
- R7: While ovf_flag is set, further overflows leave ovf_idx unchanged. A status_rd pulse clears ovf_flag on the next cycle.
- R8: Each slot's 9-bit two's-complement position equals the X byte, minus 32 when bit 7 of the colour byte is set.
- R9: Each slot's colour is the low 4 bits of the colour byte. Its pattern equals the pattern byte, with the low 2 bits forced to zero when big_spr is set.
- R10: start while idle begins a pass and raises busy. done is a one-cycle pulse that ends the pass. start while busy has no effect. A pass makes at most 128 reads.
- R11: A new pass clears all slot records to zero, so slots beyond slot_cnt read zero after the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (honoured only when idle) |
| line_num | input | 8 | Line to evaluate, latched at start |
| big_spr | input | 1 | 16x16 sprites when set, else 8x8, latched at start |
| mag_spr | input | 1 | Double sprite size, latched at start |
| sat_base | input | 7 | Attribute table base, in units of 128 bytes |
| status_rd | input | 1 | Status read pulse, clears the overflow flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 14 | Memory read address |
| mem_data | input | 8 | Read data, valid the cycle after mem_rd |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| slot_cnt | output | 3 | Number of accepted sprites (0 to 4) |
| slot_pos | output | 36 | Four 9-bit signed positions, slot 0 in the low bits |
| slot_pat | output | 32 | Four 8-bit pattern numbers |
| slot_col | output | 16 | Four 4-bit colours |
| ovf_flag | output | 1 | Fifth-sprite flag |
| ovf_idx | output | 5 | Index of the overflowing entry |

## Verification
The checker watches the overflow and pass control on every cycle. It checks that the flag rises only with all four slots full, that it holds its index while set, and that it clears after a status read. It also checks that reads happen only inside a pass, that done lasts one cycle, that slot_cnt never exceeds four and grows one step at a time, and that a pass stays within the read budget. The coverage arithmetic and table-order selection only show up in the bench's scenarios. So do the end marker, the wrap at Y = 255, the early shift, pattern alignment and slot clearing. The bench sets these up with a prepared table and compares the slot records with its own walk of that table.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_Y_REQ,
    ST_Y_CHK,
    ST_A_REQ,
    ST_A_CAP,
    ST_FIN
  } seq_state_t;

  // Effective sprite height in lines.
  function automatic logic [7:0] spr_height(input logic big, input logic mag);
    logic [7:0] h;
    h = big ? 8'd16 : 8'd8;
    if (mag) h = h << 1;
    return h;
  endfunction

  // Row offset of a line inside a sprite; the sprite starts one line below Y.
  function automatic logic [7:0] spr_row(input logic [7:0] line, input logic [7:0] y);
    return line - y - 8'd1;
  endfunction

  function automatic logic spr_covers(input logic [7:0] line, input logic [7:0] y,
                                      input logic big, input logic mag);
    return spr_row(line, y) < spr_height(big, mag);
  endfunction

  // Signed horizontal position after the optional early shift.
  function automatic logic [8:0] spr_xpos(input logic [7:0] x, input logic early);
    return early ? ({1'b0, x} - 9'd32) : {1'b0, x};
  endfunction

  function automatic logic [7:0] spr_pat_align(input logic [7:0] pat, input logic big);
    return big ? {pat[7:2], 2'b00} : pat;
  endfunction

endpackage

// File: rtl/spr_eval_seq.sv
module spr_eval_seq
  import spr_eval_pkg::*;
#(
  parameter int NUM_SPR   = 32,
  parameter int NUM_SLOTS = 4,
  parameter int AW        = 14,
  parameter int STOP_Y    = 208,
  localparam int IDX_W    = $clog2(NUM_SPR),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BASE_W   = AW - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        line_num,
  input  logic              big_spr,
  input  logic              mag_spr,
  input  logic [BASE_W-1:0] sat_base,
  input  logic [7:0]        mem_data,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  output logic              busy,
  output logic              done,
  output logic              clr,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [1:0]        wr_field,
  output logic              cur_big,
  output logic              ovf_hit,
  output logic [IDX_W-1:0]  ovf_at,
  output logic [CNT_W-1:0]  slot_cnt
);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        byte_sel;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        line_q;
  logic              big_q;
  logic              mag_q;
  logic [BASE_W-1:0] base_q;

  logic y_stop;
  logic y_hit;
  logic slots_full;
  logic last_entry;

  always_comb begin
    mem_rd     = (state == ST_Y_REQ) || (state == ST_A_REQ);
    mem_addr   = {base_q, idx, (state == ST_Y_REQ) ? 2'b00 : byte_sel};
    y_stop     = (state == ST_Y_CHK) && (mem_data == 8'(STOP_Y));
    y_hit      = (state == ST_Y_CHK) && !y_stop && spr_covers(line_q, mem_data, big_q, mag_q);
    slots_full = (cnt == CNT_W'(NUM_SLOTS));
    ovf_hit    = y_hit && slots_full;
    ovf_at     = idx;
    last_entry = (idx == IDX_W'(NUM_SPR - 1));
    wr_en      = (state == ST_A_CAP);
    wr_slot    = cnt[SLOT_W-1:0];
    wr_field   = byte_sel;
    clr        = start && (state == ST_IDLE);
    busy       = (state != ST_IDLE);
    done       = (state == ST_FIN);
    cur_big    = big_q;
    slot_cnt   = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      byte_sel <= 2'd0;
      cnt      <= '0;
      line_q   <= 8'd0;
      big_q    <= 1'b0;
      mag_q    <= 1'b0;
      base_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            line_q   <= line_num;
            big_q    <= big_spr;
            mag_q    <= mag_spr;
            base_q   <= sat_base;
            idx      <= '0;
            cnt      <= '0;
            byte_sel <= 2'd0;
            state    <= ST_Y_REQ;
          end
        end
        ST_Y_REQ: state <= ST_Y_CHK;
        ST_Y_CHK: begin
          if (y_stop || ovf_hit) begin
            state <= ST_FIN;
          end else if (y_hit) begin
            byte_sel <= 2'd1;
            state    <= ST_A_REQ;
          end else if (last_entry) begin
            state <= ST_FIN;
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= ST_Y_REQ;
          end
        end
        ST_A_REQ: state <= ST_A_CAP;
        ST_A_CAP: begin
          if (byte_sel == 2'd3) begin
            cnt <= cnt + CNT_W'(1);
            if (last_entry) begin
              state <= ST_FIN;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= ST_Y_REQ;
            end
          end else begin
            byte_sel <= byte_sel + 2'd1;
            state    <= ST_A_REQ;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spr_slot_bank.sv
module spr_slot_bank
  import spr_eval_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  logic [1:0]             wr_field,
  input  logic [7:0]             wr_data,
  input  logic                   big,
  output logic [NUM_SLOTS*9-1:0] slot_pos,
  output logic [NUM_SLOTS*8-1:0] slot_pat,
  output logic [NUM_SLOTS*4-1:0] slot_col
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic       sel;
    logic [7:0] x_q;
    logic [7:0] pat_q;
    logic [3:0] col_q;
    logic       early_q;

    assign sel = wr_en && (wr_slot == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_q     <= 8'd0;
        pat_q   <= 8'd0;
        col_q   <= 4'd0;
        early_q <= 1'b0;
      end else if (clr) begin
        x_q     <= 8'd0;
        pat_q   <= 8'd0;
        col_q   <= 4'd0;
        early_q <= 1'b0;
      end else if (sel) begin
        case (wr_field)
          2'd1:    x_q   <= wr_data;
          2'd2:    pat_q <= spr_pat_align(wr_data, big);
          2'd3: begin
            col_q   <= wr_data[3:0];
            early_q <= wr_data[7];
          end
          default: ;
        endcase
      end
    end

    assign slot_pos[g*9 +: 9] = spr_xpos(x_q, early_q);
    assign slot_pat[g*8 +: 8] = pat_q;
    assign slot_col[g*4 +: 4] = col_q;
  end

endmodule

// File: rtl/spr_ovf_reg.sv
module spr_ovf_reg #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             status_rd,
  output logic             flag,
  output logic [IDX_W-1:0] idx
);

  logic take;
  assign take = hit && (!flag || status_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      idx  <= '0;
    end else if (take) begin
      flag <= 1'b1;
      idx  <= hit_idx;
    end else if (status_rd) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval #(
  parameter int NUM_SPR   = 32,
  parameter int NUM_SLOTS = 4,
  parameter int AW        = 14,
  parameter int STOP_Y    = 208,
  localparam int IDX_W    = $clog2(NUM_SPR),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BASE_W   = AW - IDX_W - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [7:0]             line_num,
  input  logic                   big_spr,
  input  logic                   mag_spr,
  input  logic [BASE_W-1:0]      sat_base,
  input  logic                   status_rd,
  output logic                   mem_rd,
  output logic [AW-1:0]          mem_addr,
  input  logic [7:0]             mem_data,
  output logic                   busy,
  output logic                   done,
  output logic [CNT_W-1:0]       slot_cnt,
  output logic [NUM_SLOTS*9-1:0] slot_pos,
  output logic [NUM_SLOTS*8-1:0] slot_pat,
  output logic [NUM_SLOTS*4-1:0] slot_col,
  output logic                   ovf_flag,
  output logic [IDX_W-1:0]       ovf_idx
);

  // Internal events, named for the checker.
  logic              clr;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [1:0]        wr_field;
  logic              cur_big;
  logic              ovf_hit;
  logic [IDX_W-1:0]  ovf_at;

  spr_eval_seq #(
    .NUM_SPR(NUM_SPR), .NUM_SLOTS(NUM_SLOTS), .AW(AW), .STOP_Y(STOP_Y)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .line_num(line_num),
    .big_spr(big_spr), .mag_spr(mag_spr), .sat_base(sat_base),
    .mem_data(mem_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .busy(busy), .done(done), .clr(clr), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_field(wr_field), .cur_big(cur_big), .ovf_hit(ovf_hit),
    .ovf_at(ovf_at), .slot_cnt(slot_cnt)
  );

  spr_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_field(wr_field), .wr_data(mem_data), .big(cur_big),
    .slot_pos(slot_pos), .slot_pat(slot_pat), .slot_col(slot_col)
  );

  spr_ovf_reg #(.IDX_W(IDX_W)) u_ovf (
    .clk(clk), .rst_n(rst_n), .hit(ovf_hit), .hit_idx(ovf_at),
    .status_rd(status_rd), .flag(ovf_flag), .idx(ovf_idx)
  );

endmodule

// File: rtl/spr_line_eval_chk.sv
module spr_line_eval_chk #(
  parameter int CNT_W     = 3,
  parameter int IDX_W     = 5,
  parameter int NUM_SLOTS = 4,
  parameter int MAX_RD    = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             status_rd,
  input logic             mem_rd,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] slot_cnt,
  input logic             ovf_flag,
  input logic [IDX_W-1:0] ovf_idx,
  input logic             ovf_hit
);

  // Reads issued since the current pass began.
  logic [15:0] rd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_cnt <= 16'd0;
    else if (start && !busy)   rd_cnt <= 16'd0;
    else if (mem_rd)           rd_cnt <= rd_cnt + 16'd1;
  end

  AST_RD_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_RD_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (rd_cnt < 16'(MAX_RD))); // R10
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= CNT_W'(NUM_SLOTS)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (slot_cnt == $past(slot_cnt)) || (slot_cnt == CNT_W'($past(slot_cnt) + 1'b1))); // R4
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (slot_cnt == CNT_W'(NUM_SLOTS))); // R6
  AST_HIT_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |-> busy); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !status_rd) |=> (ovf_flag && $stable(ovf_idx))); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ovf_hit) |=> !ovf_flag); // R7

endmodule

bind spr_line_eval spr_line_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .status_rd(status_rd),
  .mem_rd(mem_rd), .busy(busy), .done(done), .slot_cnt(slot_cnt),
  .ovf_flag(ovf_flag), .ovf_idx(ovf_idx), .ovf_hit(ovf_hit)
);

// File: tb/spr_line_eval_test.sv
`timescale 1ns/1ps
module spr_line_eval_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  line_num = 8'd0;
  logic        big_spr = 1'b0;
  logic        mag_spr = 1'b0;
  logic [6:0]  sat_base = 7'h15;
  logic        status_rd = 1'b0;
  logic        mem_rd;
  logic [13:0] mem_addr;
  logic [7:0]  mem_data;
  logic        busy, done;
  logic [2:0]  slot_cnt;
  logic [35:0] slot_pos;
  logic [31:0] slot_pat;
  logic [15:0] slot_col;
  logic        ovf_flag;
  logic [4:0]  ovf_idx;

  always #4 clk = ~clk;

  spr_line_eval uut (
    .clk(clk), .rst_n(rst_n), .start(start), .line_num(line_num),
    .big_spr(big_spr), .mag_spr(mag_spr), .sat_base(sat_base),
    .status_rd(status_rd), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .done(done), .slot_cnt(slot_cnt),
    .slot_pos(slot_pos), .slot_pat(slot_pat), .slot_col(slot_col),
    .ovf_flag(ovf_flag), .ovf_idx(ovf_idx)
  );

  // Table memory: one 128-byte window, the base is checked separately.
  logic [7:0] mem [0:127];
  logic [7:0] rdata;
  always_ff @(posedge clk) if (mem_rd) rdata <= mem[mem_addr[6:0]];
  assign mem_data = rdata;

  int tests = 0;
  int fails = 0;
  int pass_reads = 0;
  int max_entry = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R2: every read lands inside the selected table window.
  always @(negedge clk) begin
    if (rst_n && mem_rd) begin
      pass_reads++;
      if (int'(mem_addr[6:2]) > max_entry) max_entry = int'(mem_addr[6:2]);
      if (mem_addr[13:7] != sat_base) begin
        tests++; fails++;
        $display("FAIL R2 read base: actual %0d expected %0d", mem_addr[13:7], sat_base);
      end
    end
  end

  // Reference walk of the table, written from the requirements.
  int e_cnt, e_ovf, e_idx;
  int e_pos [4];
  int e_pat [4];
  int e_col [4];

  task automatic model(input int ln, input bit bg, input bit mg);
    int h;
    h = 8;
    if (bg) h = 16;
    if (mg) h = h * 2;
    e_cnt = 0; e_ovf = 0; e_idx = 0;
    for (int s = 0; s < 4; s++) begin e_pos[s] = 0; e_pat[s] = 0; e_col[s] = 0; end
    for (int i = 0; i < 32; i++) begin
      int y, top, row;
      y = int'(mem[4*i]);
      if (y == 208) break;
      top = (y + 1) % 256;
      row = (ln - top + 256) % 256;
      if (row < h) begin
        if (e_cnt == 4) begin e_ovf = 1; e_idx = i; break; end
        e_pos[e_cnt] = int'(mem[4*i+1]) - ((mem[4*i+3] >= 8'h80) ? 32 : 0);
        e_pat[e_cnt] = bg ? (int'(mem[4*i+2]) / 4) * 4 : int'(mem[4*i+2]);
        e_col[e_cnt] = int'(mem[4*i+3]) % 16;
        e_cnt++;
      end
    end
  endtask

  task automatic check_slots(input string tag);
    for (int s = 0; s < 4; s++) begin
      chk(slot_pos[s*9 +: 9] == 9'(e_pos[s]), "R8", {tag, " position"},
          int'(slot_pos[s*9 +: 9]), e_pos[s] & 511);
      chk(slot_pat[s*8 +: 8] == 8'(e_pat[s]), "R9", {tag, " pattern"},
          int'(slot_pat[s*8 +: 8]), e_pat[s]);
      chk(slot_col[s*4 +: 4] == 4'(e_col[s]), (s >= e_cnt) ? "R11" : "R9", {tag, " colour"},
          int'(slot_col[s*4 +: 4]), e_col[s]);
    end
  endtask

  task automatic pulse_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic run_pass(input logic [7:0] ln, input logic bg, input logic mg);
    int n;
    @(negedge clk);
    line_num = ln; big_spr = bg; mag_spr = mg; start = 1'b1;
    pass_reads = 0; max_entry = 0;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) begin
      chk(1'b0, "R10", "pass timeout", n, 0);
    end else begin
      @(negedge clk);
      chk(!done && !busy, "R10", "done width", int'(done), 0);
    end
  endtask

  task automatic put(input int i, input int y, input int x, input int p, input int c);
    mem[4*i] = 8'(y); mem[4*i+1] = 8'(x); mem[4*i+2] = 8'(p); mem[4*i+3] = 8'(c);
  endtask

  // {line, big, mag, count, overflow, overflow index}
  localparam logic [18:0] VEC [0:12] = '{
    {8'd10,  1'b0, 1'b0, 3'd4, 1'b1, 5'd6},
    {8'd0,   1'b0, 1'b0, 3'd1, 1'b0, 5'd0},
    {8'd41,  1'b0, 1'b0, 3'd1, 1'b0, 5'd0},
    {8'd48,  1'b0, 1'b0, 3'd1, 1'b0, 5'd0},
    {8'd49,  1'b0, 1'b0, 3'd0, 1'b0, 5'd0},
    {8'd49,  1'b1, 1'b0, 3'd1, 1'b0, 5'd0},
    {8'd20,  1'b1, 1'b0, 3'd4, 1'b1, 5'd6},
    {8'd20,  1'b0, 1'b0, 3'd0, 1'b0, 5'd0},
    {8'd40,  1'b1, 1'b1, 3'd4, 1'b1, 5'd6},
    {8'd15,  1'b1, 1'b1, 3'd4, 1'b1, 5'd5},
    {8'd101, 1'b0, 1'b0, 3'd0, 1'b0, 5'd0},
    {8'd25,  1'b0, 1'b1, 3'd4, 1'b1, 5'd6},
    {8'd26,  1'b0, 1'b1, 3'd0, 1'b0, 5'd0}
  };

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 128; a++) mem[a] = 8'd0;
    put(0, 9,   100, 8'h13, 8'h85);
    put(1, 9,   20,  8'h22, 8'h03);
    put(2, 40,  50,  8'h07, 8'h0C);
    put(3, 9,   5,   8'h41, 8'h8F);
    put(4, 255, 200, 8'h10, 8'h01);
    put(5, 9,   60,  8'h33, 8'h02);
    put(6, 9,   70,  8'h05, 8'h04);
    put(7, 208, 0,   0,     0);
    put(8, 100, 1,   2,     3);

    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!busy && !done && !mem_rd, "R1", "control idle", int'({busy, done, mem_rd}), 0);
    chk(slot_cnt == 3'd0, "R1", "slot count", int'(slot_cnt), 0);
    chk(!ovf_flag && ovf_idx == 5'd0, "R1", "overflow", int'({ovf_flag, ovf_idx}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table-driven passes: R3, R4, R5, R6 counts plus slot contents.
    for (int v = 0; v < 13; v++) begin
      logic [7:0] ln; logic bg, mg; logic [2:0] ec; logic eo; logic [4:0] ei;
      {ln, bg, mg, ec, eo, ei} = VEC[v];
      pulse_status();
      run_pass(ln, bg, mg);
      chk(slot_cnt == ec, "R3", $sformatf("vec %0d count", v), int'(slot_cnt), int'(ec));
      chk(ovf_flag == eo, "R6", $sformatf("vec %0d flag", v), int'(ovf_flag), int'(eo));
      if (eo) chk(ovf_idx == ei, "R6", $sformatf("vec %0d index", v), int'(ovf_idx), int'(ei));
      chk(max_entry <= 7, "R5", $sformatf("vec %0d entries read", v), max_entry, 7);
      model(int'(ln), bg, mg);
      chk(int'(slot_cnt) == e_cnt, "R4", $sformatf("vec %0d model count", v), int'(slot_cnt), e_cnt);
      check_slots($sformatf("vec %0d", v));
    end

    // R7: the flag is sticky and keeps the first index until a status read.
    pulse_status();
    run_pass(8'd10, 1'b0, 1'b0);
    run_pass(8'd15, 1'b1, 1'b1);
    chk(ovf_flag, "R7", "flag held", int'(ovf_flag), 1);
    chk(ovf_idx == 5'd6, "R7", "index held", int'(ovf_idx), 6);
    pulse_status();
    chk(!ovf_flag, "R7", "flag cleared", int'(ovf_flag), 0);
    run_pass(8'd15, 1'b1, 1'b1);
    chk(ovf_idx == 5'd5, "R7", "index after clear", int'(ovf_idx), 5);

    // R10: start during a pass is ignored; the line latched first wins.
    pulse_status();
    @(negedge clk); line_num = 8'd0; big_spr = 1'b0; mag_spr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    line_num = 8'd10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
    end
    repeat (5) @(negedge clk);
    chk(!busy, "R10", "no second pass", int'(busy), 0);
    chk(slot_cnt == 3'd1, "R10", "first line kept", int'(slot_cnt), 1);
    chk(slot_pos[8:0] == 9'd200, "R10", "slot0 from first line", int'(slot_pos[8:0]), 200);

    // R5/R10: without an end marker all 32 entries are examined, one read each.
    sat_base = 7'h02;
    mem[28] = 8'd0;
    for (int i = 8; i < 32; i++) mem[4*i] = 8'd0;
    run_pass(8'd200, 1'b0, 1'b0);
    chk(pass_reads == 32, "R10", "reads in full walk", pass_reads, 32);
    chk(max_entry == 31, "R5", "last entry reached", max_entry, 31);
    chk(slot_cnt == 3'd0, "R3", "no cover", int'(slot_cnt), 0);

    // R2/R4: Y=0 entries cover line 3; entry 4 (Y=255) comes first in order.
    pulse_status();
    run_pass(8'd3, 1'b0, 1'b0);
    model(3, 1'b0, 1'b0);
    chk(slot_cnt == 3'd4, "R4", "wrap count", int'(slot_cnt), 4);
    chk(ovf_flag && ovf_idx == 5'd10, "R6", "wrap overflow index", int'(ovf_idx), 10);
    check_slots("wrap");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule